// File: doc/BRIEF.md
# Result Dispatch and Method Sender

This unit sits behind the execute stage of a small command-processing engine. Each accepted instruction hands it a 32-bit result, a 3-bit result-operation code and a destination register index. From the code it decides whether the destination register takes the result or a fresh value popped from the parameter FIFO. It also decides whether the result is loaded as the new method address, and what value, if any, goes out on the downstream register-write bus.

The method address is an 18-bit value. Its low 12 bits are the target address and bits 17:12 are an auto-increment step. Every send goes to the current address, and the step is then added to the address, modulo 4096. A run begins with `run_start`. The unit then pops the first parameter into register 1 on its own, and instruction parameters are taken from the second FIFO entry onward. A run ends with `run_exit`, and any parameter still waiting at that point raises a sticky error flag.

Top module: `result_dispatch`

## Requirements
- R1: After reset, `rf_we`, `snd_valid`, `run_err`, `meth_addr` and `meth_incr` are all zero, and an instruction that needs no parameter is accepted (`op_ready` high).
- R2: `run_start` clears the method address, the increment and `run_err`. In the next cycle in which `par_valid` is high, the unit pops one entry and writes it to register 1, one cycle later. `op_ready` stays low from the `run_start` cycle until that pop.
- R3: The destination takes the popped parameter for codes 0, 3 and 5, and the instruction result for codes 1, 2, 4, 6 and 7. A destination index of 0 never raises `rf_we`.
- R4: Codes 2, 5, 6 and 7 load result bits 11:0 as the method address and result bits 17:12 as the increment. Other codes leave the increment unchanged.
- R5: Codes 3 and 4 send the result. Code 6 sends a newly popped parameter. Code 7 sends result bits 17:12, zero-extended. Codes 0, 1, 2 and 5 send nothing.
- R6: A send goes to the method address in effect after any load by the same instruction. After the send, the address advances by the increment, modulo 4096.
- R7: An instruction that needs a parameter (codes 0, 3, 5 and 6) is held with `op_ready` low while `par_valid` is low. During the hold, no register write and no send occurs. The instruction is accepted in the cycle data appears.
- R8: `par_pop` is high only while `par_valid` is high. Each accepted parameter-consuming instruction pops exactly one entry.
- R9: `run_exit` while `par_valid` is high sets `run_err`, which holds until the next `run_start`. `run_exit` with an empty FIFO leaves it clear.
- R10: Register-write and send outputs appear on the clock edge after acceptance and last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_start | input | 1 | Begin a run: clear state, schedule preload of register 1 |
| run_exit | input | 1 | End of run: check that the FIFO is drained |
| op_valid | input | 1 | Instruction result present |
| op_ready | output | 1 | Instruction accepted this cycle when high with op_valid |
| op_code | input | 3 | Result-operation code |
| op_dst | input | RAW | Destination register index |
| op_result | input | DW | Instruction result |
| par_valid | input | 1 | Parameter FIFO not empty |
| par_data | input | DW | Head of parameter FIFO |
| par_pop | output | 1 | Pop the FIFO head |
| rf_we | output | 1 | Register write strobe |
| rf_addr | output | RAW | Register write index |
| rf_wdata | output | DW | Register write data |
| snd_valid | output | 1 | Downstream write strobe |
| snd_addr | output | MAW | Downstream write address |
| snd_data | output | DW | Downstream write data |
| meth_addr | output | MAW | Current method address |
| meth_incr | output | MIW | Current method increment |
| run_err | output | 1 | Parameters were left over at exit |

## Verification
The assertions assume that `run_start`, `run_exit` and an accepted instruction never fall in the same cycle. They also assume that `par_data` is steady while `par_valid` is high and no pop occurs, as any FIFO head behaves. The stimulus raises at most one control input per cycle, and it serves the parameter FIFO from an array whose head moves only on `par_pop`. It starves the FIFO on purpose only to exercise the hold.

// File: rtl/rd_pkg.sv
package rd_pkg;

    typedef enum logic [2:0] {
        RC_FETCH_DROP     = 3'd0,
        RC_MOVE           = 3'd1,
        RC_MOVE_LOAD      = 3'd2,
        RC_FETCH_SENDRES  = 3'd3,
        RC_MOVE_SEND      = 3'd4,
        RC_FETCH_LOAD     = 3'd5,
        RC_MOVE_LOAD_SPAR = 3'd6,
        RC_MOVE_LOAD_SINC = 3'd7
    } rcode_e;

    typedef enum logic [1:0] {
        SS_NONE  = 2'd0,
        SS_RES   = 2'd1,
        SS_PAR   = 2'd2,
        SS_SLICE = 2'd3
    } snd_sel_e;

    typedef struct packed {
        logic     dst_from_par;
        logic     load_addr;
        snd_sel_e snd;
        logic     need_par;
    } rdec_t;

endpackage

// File: rtl/rd_opcode_decode.sv
module rd_opcode_decode
    import rd_pkg::*;
(
    input  logic [2:0] code,
    output rdec_t      dec
);
    always_comb begin
        dec = '0;
        unique case (rcode_e'(code))
            RC_FETCH_DROP:     begin dec.dst_from_par = 1'b1; end
            RC_MOVE:           begin end
            RC_MOVE_LOAD:      begin dec.load_addr = 1'b1; end
            RC_FETCH_SENDRES:  begin dec.dst_from_par = 1'b1; dec.snd = SS_RES; end
            RC_MOVE_SEND:      begin dec.snd = SS_RES; end
            RC_FETCH_LOAD:     begin dec.dst_from_par = 1'b1; dec.load_addr = 1'b1; end
            RC_MOVE_LOAD_SPAR: begin dec.load_addr = 1'b1; dec.snd = SS_PAR; end
            RC_MOVE_LOAD_SINC: begin dec.load_addr = 1'b1; dec.snd = SS_SLICE; end
            default:           begin end
        endcase
        dec.need_par = dec.dst_from_par || (dec.snd == SS_PAR);
    end
endmodule

// File: rtl/rd_method_addr.sv
module rd_method_addr #(
    parameter int MAW = 12,
    parameter int MIW = 6
) (
    input  logic               clear,
    input  logic [MAW-1:0]     cur_addr,
    input  logic [MIW-1:0]     cur_incr,
    input  logic               load,
    input  logic [MAW+MIW-1:0] load_val,
    input  logic               send,
    output logic [MAW-1:0]     send_addr,
    output logic [MAW-1:0]     nxt_addr,
    output logic [MIW-1:0]     nxt_incr
);
    logic [MAW-1:0] base_addr;
    logic [MIW-1:0] base_incr;

    always_comb begin
        if (clear) begin
            base_addr = '0;
            base_incr = '0;
        end else if (load) begin
            base_addr = load_val[MAW-1:0];
            base_incr = load_val[MAW+MIW-1:MAW];
        end else begin
            base_addr = cur_addr;
            base_incr = cur_incr;
        end
        send_addr = base_addr;
        nxt_incr  = base_incr;
        nxt_addr  = send ? base_addr + MAW'(base_incr) : base_addr;
    end
endmodule

// File: rtl/result_dispatch.sv
module result_dispatch
    import rd_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RAW = 3,
    parameter int MAW = 12,
    parameter int MIW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_start,
    input  logic           run_exit,
    input  logic           op_valid,
    output logic           op_ready,
    input  logic [2:0]     op_code,
    input  logic [RAW-1:0] op_dst,
    input  logic [DW-1:0]  op_result,
    input  logic           par_valid,
    input  logic [DW-1:0]  par_data,
    output logic           par_pop,
    output logic           rf_we,
    output logic [RAW-1:0] rf_addr,
    output logic [DW-1:0]  rf_wdata,
    output logic           snd_valid,
    output logic [MAW-1:0] snd_addr,
    output logic [DW-1:0]  snd_data,
    output logic [MAW-1:0] meth_addr,
    output logic [MIW-1:0] meth_incr,
    output logic           run_err
);
    localparam int MW = MAW + MIW;
    localparam logic [RAW-1:0] PRELOAD_REG = RAW'(1);

    typedef struct packed {
        logic           pend;
        logic           err;
        logic           rf_we;
        logic [RAW-1:0] rf_addr;
        logic [DW-1:0]  rf_wdata;
        logic           snd_valid;
        logic [MAW-1:0] snd_addr;
        logic [DW-1:0]  snd_data;
        logic [MAW-1:0] maddr;
        logic [MIW-1:0] mincr;
    } st_t;

    st_t   st_d, st_q;
    rdec_t dec;
    logic  fire, preload, do_send;
    logic [MAW-1:0] ma_send, ma_nxt;
    logic [MIW-1:0] mi_nxt;

    rd_opcode_decode u_dec (
        .code (op_code),
        .dec  (dec)
    );

    assign op_ready = !st_q.pend && !run_start && (par_valid || !dec.need_par);
    assign fire     = op_valid && op_ready;
    assign preload  = st_q.pend && par_valid;
    assign par_pop  = preload || (fire && dec.need_par);
    assign do_send  = fire && (dec.snd != SS_NONE);

    rd_method_addr #(.MAW(MAW), .MIW(MIW)) u_ma (
        .clear     (run_start),
        .cur_addr  (st_q.maddr),
        .cur_incr  (st_q.mincr),
        .load      (fire && dec.load_addr),
        .load_val  (op_result[MW-1:0]),
        .send      (do_send),
        .send_addr (ma_send),
        .nxt_addr  (ma_nxt),
        .nxt_incr  (mi_nxt)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rf_we     = 1'b0;
        st_d.snd_valid = 1'b0;
        st_d.maddr     = ma_nxt;
        st_d.mincr     = mi_nxt;

        if (run_start) begin
            st_d.pend = 1'b1;
            st_d.err  = 1'b0;
        end else if (run_exit && par_valid) begin
            st_d.err = 1'b1;
        end

        if (preload) begin
            st_d.pend     = 1'b0;
            st_d.rf_we    = 1'b1;
            st_d.rf_addr  = PRELOAD_REG;
            st_d.rf_wdata = par_data;
        end else if (fire) begin
            st_d.rf_we    = (op_dst != '0);
            st_d.rf_addr  = op_dst;
            st_d.rf_wdata = dec.dst_from_par ? par_data : op_result;
            if (do_send) begin
                st_d.snd_valid = 1'b1;
                st_d.snd_addr  = ma_send;
                unique case (dec.snd)
                    SS_RES:   st_d.snd_data = op_result;
                    SS_PAR:   st_d.snd_data = par_data;
                    SS_SLICE: st_d.snd_data = {{(DW-MIW){1'b0}}, op_result[MW-1:MAW]};
                    default:  st_d.snd_data = op_result;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rf_we     = st_q.rf_we;
    assign rf_addr   = st_q.rf_addr;
    assign rf_wdata  = st_q.rf_wdata;
    assign snd_valid = st_q.snd_valid;
    assign snd_addr  = st_q.snd_addr;
    assign snd_data  = st_q.snd_data;
    assign meth_addr = st_q.maddr;
    assign meth_incr = st_q.mincr;
    assign run_err   = st_q.err;
endmodule

// File: rtl/rd_checker.sv
module rd_checker #(
    parameter int DW  = 32,
    parameter int RAW = 3,
    parameter int MAW = 12,
    parameter int MIW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run_start,
    input logic           run_exit,
    input logic           op_valid,
    input logic           op_ready,
    input logic [2:0]     op_code,
    input logic [RAW-1:0] op_dst,
    input logic           par_valid,
    input logic           par_pop,
    input logic           rf_we,
    input logic [RAW-1:0] rf_addr,
    input logic           snd_valid,
    input logic [MAW-1:0] snd_addr,
    input logic [MAW-1:0] meth_addr,
    input logic [MIW-1:0] meth_incr,
    input logic           run_err
);
    logic           acc, acc_par, acc_plain_send, acc_quiet;
    logic [MAW-1:0] adv_addr;

    assign acc            = op_valid && op_ready;
    assign acc_par        = (op_code == 3'd0) || (op_code == 3'd3) ||
                            (op_code == 3'd5) || (op_code == 3'd6);
    assign acc_plain_send = acc && ((op_code == 3'd3) || (op_code == 3'd4));
    assign acc_quiet      = acc && ((op_code == 3'd0) || (op_code == 3'd1) ||
                                    (op_code == 3'd2) || (op_code == 3'd5));
    assign adv_addr       = meth_addr + MAW'(meth_incr);

    p_pop_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        par_pop |-> par_valid);

    p_pop_per_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && acc_par) |-> par_pop);

    p_hold_on_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && acc_par && !par_valid) |-> !op_ready);

    p_no_zero_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_addr != '0));

    p_send_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_plain_send |=> (snd_valid && snd_addr == $past(meth_addr) &&
                            meth_addr == $past(adv_addr)));

    p_quiet_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_quiet |=> !snd_valid);

    p_preload_reg1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (par_pop && !acc) |=> (rf_we && rf_addr == RAW'(1)));

    p_leftover_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_exit && par_valid && !run_start) |=> run_err);

    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> (!run_err && meth_addr == '0 && meth_incr == '0));
endmodule

bind result_dispatch rd_checker #(.DW(DW), .RAW(RAW), .MAW(MAW), .MIW(MIW)) u_rd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_start (run_start),
    .run_exit  (run_exit),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_code   (op_code),
    .op_dst    (op_dst),
    .par_valid (par_valid),
    .par_pop   (par_pop),
    .rf_we     (rf_we),
    .rf_addr   (rf_addr),
    .snd_valid (snd_valid),
    .snd_addr  (snd_addr),
    .meth_addr (meth_addr),
    .meth_incr (meth_incr),
    .run_err   (run_err)
);

// File: tb/result_dispatch_tb_top.sv
module result_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_start = 1'b0, run_exit = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [2:0]  op_code = '0;
    logic [2:0]  op_dst = '0;
    logic [31:0] op_result = '0;
    logic        par_valid;
    logic [31:0] par_data;
    logic        par_pop;
    logic        rf_we, snd_valid, run_err;
    logic [2:0]  rf_addr;
    logic [31:0] rf_wdata, snd_data;
    logic [11:0] snd_addr, meth_addr;
    logic [5:0]  meth_incr;

    logic [31:0] pmem [0:63];
    int          pidx = 0;
    int          pcount = 0;
    int          n_chk = 0, n_bad = 0;
    logic [11:0] m_addr = '0;
    logic [5:0]  m_incr = '0;

    always #4 clk = ~clk;

    assign par_valid = (pidx < pcount);
    assign par_data  = (pidx < 64) ? pmem[pidx] : 32'h0;

    always @(posedge clk) if (par_pop) pidx <= pidx + 1;

    result_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .run_exit(run_exit),
        .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
        .op_dst(op_dst), .op_result(op_result),
        .par_valid(par_valid), .par_data(par_data), .par_pop(par_pop),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .snd_valid(snd_valid), .snd_addr(snd_addr), .snd_data(snd_data),
        .meth_addr(meth_addr), .meth_incr(meth_incr), .run_err(run_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        logic [31:0] pv;
        @(negedge clk); run_start = 1'b1;
        #1 chk(op_ready == 1'b0, "R2 ready low in start cycle", 32'(op_ready), 0);
        @(negedge clk); run_start = 1'b0;
        m_addr = '0; m_incr = '0;
        chk(run_err == 1'b0, "R2 err cleared", 32'(run_err), 0);
        chk(meth_addr == 12'h0 && meth_incr == 6'h0, "R2 method cleared", {14'h0, meth_incr, meth_addr}, 0);
        #1;
        chk(op_ready == 1'b0, "R2 ready low while preload pending", 32'(op_ready), 0);
        chk(par_pop == 1'b1, "R2 preload pop", 32'(par_pop), 1);
        pv = pmem[pidx];
        @(posedge clk); #1;
        chk(rf_we && rf_addr == 3'd1, "R2 preload into register 1", {28'h0, rf_we, rf_addr}, 32'h9);
        chk(rf_wdata == pv, "R2 preload data", rf_wdata, pv);
    endtask

    task automatic do_op(input logic [2:0] c, input logic [2:0] d, input logic [31:0] r);
        bit need, wrp, ld, snd;
        logic [31:0] pv, e_wd, e_sd;
        logic [11:0] e_sa;
        need = (c == 3'd0) || (c == 3'd3) || (c == 3'd5) || (c == 3'd6);
        wrp  = (c == 3'd0) || (c == 3'd3) || (c == 3'd5);
        ld   = (c == 3'd2) || (c == 3'd5) || (c == 3'd6) || (c == 3'd7);
        snd  = (c == 3'd3) || (c == 3'd4) || (c == 3'd6) || (c == 3'd7);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_dst = d; op_result = r;
        #1;
        pv = pmem[pidx];
        chk(op_ready == 1'b1, "R7 ready with data or no need", 32'(op_ready), 1);
        chk(par_pop == need, "R8 one pop per consuming op", 32'(par_pop), 32'(need));
        e_wd = wrp ? pv : r;
        if (ld) begin m_addr = r[11:0]; m_incr = r[17:12]; end
        e_sa = m_addr;
        case (c)
            3'd6:    e_sd = pv;
            3'd7:    e_sd = {26'h0, r[17:12]};
            default: e_sd = r;
        endcase
        if (snd) m_addr = m_addr + {6'h0, m_incr};
        @(posedge clk); #1;
        op_valid = 1'b0;
        chk(rf_we == (d != 3'd0), "R3 write enable / zero dest", 32'(rf_we), 32'(d != 3'd0));
        if (d != 3'd0) begin
            chk(rf_addr == d, "R3 dest index", 32'(rf_addr), 32'(d));
            chk(rf_wdata == e_wd, "R3 dest data", rf_wdata, e_wd);
        end
        chk(snd_valid == snd, "R5 send strobe", 32'(snd_valid), 32'(snd));
        if (snd) begin
            chk(snd_data == e_sd, "R5 send data", snd_data, e_sd);
            chk(snd_addr == e_sa, "R6 send address", 32'(snd_addr), 32'(e_sa));
        end
        chk(meth_addr == m_addr, "R6 address advance/load", 32'(meth_addr), 32'(m_addr));
        chk(meth_incr == m_incr, "R4 increment", 32'(meth_incr), 32'(m_incr));
        @(posedge clk); #1;
        chk(!rf_we && !snd_valid, "R10 single-cycle strobes", {30'h0, rf_we, snd_valid}, 0);
    endtask

    task automatic do_exit(input bit e_err);
        @(negedge clk); run_exit = 1'b1;
        @(posedge clk); #1; run_exit = 1'b0;
        chk(run_err == e_err, "R9 leftover flag at exit", 32'(run_err), 32'(e_err));
        @(posedge clk); #1;
        chk(run_err == e_err, "R9 flag holds", 32'(run_err), 32'(e_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) pmem[i] = 32'hA500_0000 + i * 32'h0001_0F13;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(!rf_we && !snd_valid && !run_err, "R1 idle outputs", {29'h0, rf_we, snd_valid, run_err}, 0);
        chk(meth_addr == 0 && meth_incr == 0, "R1 method zero", {14'h0, meth_incr, meth_addr}, 0);
        @(negedge clk); rst_n = 1'b1;
        op_code = 3'd1;
        #1 chk(op_ready == 1'b1, "R1 ready after reset", 32'(op_ready), 1);

        // sweep: 1 preload + 48 fetches
        pcount = 49;
        do_start();
        for (int c = 0; c < 8; c++)
            for (int j = 0; j < 4; j++)
                for (int k = 0; k < 3; k++) begin
                    logic [2:0]  d;
                    logic [31:0] r;
                    d = (j == 0) ? 3'd0 : (j == 1) ? 3'd1 : (j == 2) ? 3'd5 : 3'd7;
                    r = (32'(c) * 32'h2468_ACE1) ^ (32'(j) * 32'h0135_7000) ^ (32'(k) * 32'h000A_5F3D);
                    do_op(3'(c), d, r);
                end
        // R6 wrap: address 0xFFE, step 5
        do_op(3'd2, 3'd4, 32'h0000_5FFE);
        do_op(3'd4, 3'd4, 32'h1234_5678);
        do_op(3'd4, 3'd2, 32'h0BAD_F00D);
        do_exit(1'b0);

        // R7 hold on empty FIFO
        pcount = pidx + 1;
        do_start();
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd3; op_dst = 3'd6; op_result = 32'hCAFE_0001;
        for (int w = 0; w < 3; w++) begin
            #1;
            chk(op_ready == 1'b0, "R7 held while empty", 32'(op_ready), 0);
            chk(par_pop == 1'b0, "R8 no pop while empty", 32'(par_pop), 0);
            @(posedge clk); #1;
            chk(!rf_we && !snd_valid, "R7 no output while held", {30'h0, rf_we, snd_valid}, 0);
            @(negedge clk);
        end
        op_code = 3'd1;
        #1 chk(op_ready == 1'b1, "R7 non-consuming op not held", 32'(op_ready), 1);
        op_valid = 1'b0;
        @(negedge clk);
        pmem[pidx] = 32'h7777_1234;
        pcount = pidx + 1;
        op_valid = 1'b0;
        m_addr = meth_addr; m_incr = meth_incr;
        do_op(3'd3, 3'd6, 32'hCAFE_0001);

        // R9 leftover
        pcount = pidx + 1;
        do_exit(1'b1);
        do_start();
        chk(run_err == 1'b0, "R9 cleared by start", 32'(run_err), 0);
        do_exit(1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule